// File: doc/BRIEF.md
# Change-Triggered Hex Digit Update Sequencer

This block keeps six latched hexadecimal LED digits in step with a 16-bit address and an 8-bit data value. The digits do not scan: each holds whatever nibble it last latched. They share one 4-bit nibble bus, and each digit has its own latch strobe. The block remembers the value it last sent to the digits and compares the live address and data against it on every clock. When they differ, it takes a snapshot and writes all six digits one after another. For each digit it sets up the nibble, pulses that digit's strobe, and then holds the nibble.

The sequence is set by three parameters: a setup time with the strobe low, a strobe pulse width, and a hold time. Inputs that move while a sequence runs do not disturb it. When the sequence ends, the latest inputs are compared again, and a further pass starts if they still differ from what was shipped. Three blanking outputs, one per byte-wide digit group, are registered copies of a request input and are separate from the sequencer. After reset, one pass is forced so that the digits match the starting inputs.

Top module: `hexdisp_updater`

## Requirements
- R1: Sequence position k carries a fixed nibble: k=0 is addr_in[15:12], k=1 is [11:8], k=2 is [7:4], k=3 is [3:0], k=4 is data_in[7:4] and k=5 is data_in[3:0]. That nibble is latched by strobe[k].
- R2: A pass begins only when {addr_in, data_in} differs from the last shipped snapshot. busy rises at the first clock edge at which the block is idle and sees the difference, and the snapshot is taken at that same edge. Equal inputs leave the block idle.
- R3: At most one strobe bit is high in any cycle, and no strobe is high while busy is low.
- R4: For each digit, nib_out presents the nibble for SETUP_CLKS cycles with the strobe low. The strobe is then high for PULSE_CLKS cycles, and then low for HOLD_CLKS cycles with the nibble unchanged. nib_out is 0 while idle.
- R5: Every pass writes all six digits in the order k=0 to 5. busy stays high for exactly 6*(SETUP_CLKS+PULSE_CLKS+HOLD_CLKS) cycles.
- R6: Input changes during a pass do not alter that pass. If the inputs at its end differ from the snapshot, busy is low for exactly one cycle and the next pass ships the latest inputs.
- R7: Inputs that change during a pass and return to the shipped value before it ends start no further pass.
- R8: The first cycle after reset starts one full pass of the current inputs, even when they equal the reset snapshot of zero.
- R9: blank[g] equals blank_req[g] from one cycle earlier, whether or not a pass is running. Group 0 is the address high byte, group 1 the address low byte and group 2 the data byte.
- R10: While rst is high, busy, strobe, nib_out and blank are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_in | input | 16 | Address value to display |
| data_in | input | 8 | Data value to display |
| blank_req | input | 3 | Blanking request per digit group |
| nib_out | output | 4 | Shared nibble bus to all digits |
| strobe | output | 6 | Per-digit latch strobes |
| blank | output | 3 | Registered blanking lines per group |
| busy | output | 1 | High while a pass is in progress |

## Verification
The hardest situation to reach is the boundary at the end of a pass that collided with input activity. The outcome depends only on whether the value present at that moment differs from the snapshot, not on how many changes came before. The bench changes the inputs twice during a pass and then checks three things: busy drops for exactly one cycle, the follow-up pass carries only the second value, and the strobe timing is unchanged. A separate pass changes the inputs and then restores the shipped value before the end, and the bench checks that the block then stays idle.

// File: rtl/hexdisp_pkg.sv
package hexdisp_pkg;

    localparam int NIB_W   = 4;
    localparam int GROUP_W = 8;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_PULSE = 2'd2,
        PH_HOLD  = 2'd3
    } phase_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/hexdisp_track.sv
module hexdisp_track
    import hexdisp_pkg::*;
#(
    parameter int SNAP_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SNAP_W-1:0] live,
    input  logic              busy,
    output logic [SNAP_W-1:0] snap,
    output logic              start
);

    logic [SNAP_W-1:0] shipped;
    logic              force_pass;
    logic              differs;

    assign differs = (live != shipped);
    assign start   = !busy && (differs || force_pass);
    assign snap    = shipped;

    always_ff @(posedge clk) begin
        if (rst) begin
            shipped    <= '0;
            force_pass <= 1'b1;
        end else if (start) begin
            shipped    <= live;
            force_pass <= 1'b0;
        end
    end

    // R6: snapshot frozen while a pass runs
    p_snap_frozen_r6: assert property (@(posedge clk) disable iff (rst)
        busy && $past(busy) |-> $stable(shipped));

    // R2: a start request is picked up by the sequencer
    p_start_runs_r2: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);

endmodule

// File: rtl/hexdisp_stepper.sv
module hexdisp_stepper
    import hexdisp_pkg::*;
#(
    parameter int SNAP_W     = 24,
    parameter int SETUP_CLKS = 2,
    parameter int PULSE_CLKS = 3,
    parameter int HOLD_CLKS  = 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic [SNAP_W-1:0]        snap,
    output logic                     busy,
    output logic [NIB_W-1:0]         nib_out,
    output logic [SNAP_W/NIB_W-1:0]  strobe
);

    localparam int NDIG   = SNAP_W / NIB_W;
    localparam int DIG_W  = (NDIG > 1) ? $clog2(NDIG) : 1;
    localparam int MAXLEN = max3(SETUP_CLKS, PULSE_CLKS, HOLD_CLKS);
    localparam int CNT_W  = (MAXLEN > 1) ? $clog2(MAXLEN) : 1;

    typedef struct packed {
        phase_e           ph;
        logic [DIG_W-1:0] dig;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t cur, nxt;
    logic [CNT_W-1:0] lim;
    logic             at_end;
    logic [NIB_W-1:0] nibs [NDIG];
    logic [NIB_W-1:0] nib_sel;

    // nibble k counted from the most significant end of the snapshot
    for (genvar k = 0; k < NDIG; k++) begin : g_nib
        assign nibs[k] = snap[SNAP_W-1-NIB_W*k -: NIB_W];
    end

    always_comb begin
        case (cur.ph)
            PH_SETUP: lim = CNT_W'(SETUP_CLKS - 1);
            PH_PULSE: lim = CNT_W'(PULSE_CLKS - 1);
            PH_HOLD:  lim = CNT_W'(HOLD_CLKS - 1);
            default:  lim = '0;
        endcase
    end

    assign at_end = (cur.cnt == lim);

    always_comb begin
        nxt = cur;
        case (cur.ph)
            PH_IDLE: begin
                if (start) begin
                    nxt.ph  = PH_SETUP;
                    nxt.dig = '0;
                    nxt.cnt = '0;
                end
            end
            PH_SETUP: begin
                if (at_end) begin
                    nxt.ph  = PH_PULSE;
                    nxt.cnt = '0;
                end else begin
                    nxt.cnt = cur.cnt + 1'b1;
                end
            end
            PH_PULSE: begin
                if (at_end) begin
                    nxt.ph  = PH_HOLD;
                    nxt.cnt = '0;
                end else begin
                    nxt.cnt = cur.cnt + 1'b1;
                end
            end
            PH_HOLD: begin
                if (at_end) begin
                    nxt.cnt = '0;
                    if (cur.dig == DIG_W'(NDIG - 1)) begin
                        nxt.ph  = PH_IDLE;
                        nxt.dig = '0;
                    end else begin
                        nxt.ph  = PH_SETUP;
                        nxt.dig = cur.dig + 1'b1;
                    end
                end else begin
                    nxt.cnt = cur.cnt + 1'b1;
                end
            end
            default: nxt.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur.ph  <= PH_IDLE;
            cur.dig <= '0;
            cur.cnt <= '0;
        end else begin
            cur <= nxt;
        end
    end

    always_comb begin
        nib_sel = '0;
        if (int'(cur.dig) < NDIG) nib_sel = nibs[cur.dig];
    end

    assign busy    = (cur.ph != PH_IDLE);
    assign nib_out = busy ? nib_sel : '0;

    for (genvar k = 0; k < NDIG; k++) begin : g_strobe
        assign strobe[k] = (cur.ph == PH_PULSE) && (cur.dig == DIG_W'(k));
    end

    // R3: single strobe at a time
    p_one_strobe_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(strobe));

    // R3: strobes only inside a pass
    p_strobe_in_pass_r3: assert property (@(posedge clk) disable iff (rst)
        (strobe != '0) |-> busy);

    // R4: nibble steady across the strobe and its preceding cycle
    p_nib_held_r4: assert property (@(posedge clk) disable iff (rst)
        (strobe != '0) |-> $stable(nib_out));

    // R5: digits visited in ascending order
    p_digit_step_r5: assert property (@(posedge clk) disable iff (rst)
        (cur.dig != $past(cur.dig)) |->
            (cur.dig == $past(cur.dig) + 1'b1) || (cur.dig == '0));

endmodule

// File: rtl/hexdisp_blank.sv
module hexdisp_blank #(
    parameter int GROUPS = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [GROUPS-1:0] req,
    output logic [GROUPS-1:0] blank
);

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        always_ff @(posedge clk) begin
            if (rst) blank[g] <= 1'b0;
            else     blank[g] <= req[g];
        end
    end

    // R9: an output edge needs a request edge one cycle earlier
    p_blank_cause_r9: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && !$past(rst, 2) && !$stable(blank) |->
            $past(req) != $past(req, 2));

endmodule

// File: rtl/hexdisp_updater.sv
module hexdisp_updater
    import hexdisp_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int SETUP_CLKS = 2,
    parameter int PULSE_CLKS = 3,
    parameter int HOLD_CLKS  = 1
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic [ADDR_W-1:0]                    addr_in,
    input  logic [DATA_W-1:0]                    data_in,
    input  logic [(ADDR_W+DATA_W)/GROUP_W-1:0]   blank_req,
    output logic [NIB_W-1:0]                     nib_out,
    output logic [(ADDR_W+DATA_W)/NIB_W-1:0]     strobe,
    output logic [(ADDR_W+DATA_W)/GROUP_W-1:0]   blank,
    output logic                                 busy
);

    localparam int SNAP_W = ADDR_W + DATA_W;
    localparam int NGRP   = SNAP_W / GROUP_W;

    logic [SNAP_W-1:0] live;
    logic [SNAP_W-1:0] snap;
    logic              start;

    assign live = {addr_in, data_in};

    hexdisp_track #(
        .SNAP_W (SNAP_W)
    ) u_track (
        .clk   (clk),
        .rst   (rst),
        .live  (live),
        .busy  (busy),
        .snap  (snap),
        .start (start)
    );

    hexdisp_stepper #(
        .SNAP_W     (SNAP_W),
        .SETUP_CLKS (SETUP_CLKS),
        .PULSE_CLKS (PULSE_CLKS),
        .HOLD_CLKS  (HOLD_CLKS)
    ) u_step (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .snap    (snap),
        .busy    (busy),
        .nib_out (nib_out),
        .strobe  (strobe)
    );

    hexdisp_blank #(
        .GROUPS (NGRP)
    ) u_blank (
        .clk   (clk),
        .rst   (rst),
        .req   (blank_req),
        .blank (blank)
    );

endmodule

// File: tb/hexdisp_updater_test.sv
module hexdisp_updater_test;

    localparam int S     = 2;
    localparam int P     = 3;
    localparam int H     = 1;
    localparam int PER   = S + P + H;
    localparam int TOTAL = 6 * PER;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] addr_in = 16'h0000;
    logic [7:0]  data_in = 8'h00;
    logic [2:0]  blank_req = 3'b000;
    logic [3:0]  nib_out;
    logic [5:0]  strobe;
    logic [2:0]  blank;
    logic        busy;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    hexdisp_updater #(
        .ADDR_W(16), .DATA_W(8),
        .SETUP_CLKS(S), .PULSE_CLKS(P), .HOLD_CLKS(H)
    ) uut (
        .clk(clk), .rst(rst), .addr_in(addr_in), .data_in(data_in),
        .blank_req(blank_req), .nib_out(nib_out), .strobe(strobe),
        .blank(blank), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] nib_of(input logic [15:0] a, input logic [7:0] d,
                                          input int k);
        logic [23:0] v;
        v = {a, d};
        return v[23 - 4*k -: 4];
    endfunction

    // Walks one full pass starting at a negedge where busy is expected high.
    task automatic check_pass(input logic [15:0] a, input logic [7:0] d);
        int w = 0;
        int bad_nib = 0, bad_st = 0, bad_busy = 0;
        logic [31:0] a_nib = 0, e_nib = 0, a_st = 0, e_st = 0;
        while (!busy && w < 50) begin
            @(negedge clk);
            w++;
        end
        for (int c = 0; c < TOTAL; c++) begin
            int k = c / PER;
            int ph = c % PER;
            logic [5:0] exp_st;
            exp_st = (ph >= S && ph < S + P) ? (6'b1 << k) : 6'b0;
            if (!busy) bad_busy++;
            if (nib_out !== nib_of(a, d, k) && bad_nib == 0) begin
                a_nib = 32'(nib_out); e_nib = 32'(nib_of(a, d, k));
            end
            if (nib_out !== nib_of(a, d, k)) bad_nib++;
            if (strobe !== exp_st && bad_st == 0) begin
                a_st = 32'(strobe); e_st = 32'(exp_st);
            end
            if (strobe !== exp_st) bad_st++;
            @(negedge clk);
        end
        check(bad_nib == 0, "R1", "nibble per digit", a_nib, e_nib);
        check(bad_st == 0, "R4", "strobe timing", a_st, e_st);
        check(bad_busy == 0 && busy == 1'b0, "R5", "busy span",
              32'(busy), 32'(0));
        check(nib_out == 4'h0 && strobe == 6'h0, "R3", "idle outputs quiet",
              {24'h0, strobe, 2'b0}, 32'h0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(busy == 0 && strobe == 0 && nib_out == 0 && blank == 0, "R10",
              "outputs in reset", {busy, strobe, nib_out, blank}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 1'b1, "R8", "forced pass after reset", 32'(busy), 32'd1);
        check_pass(16'h0000, 8'h00);
    endtask

    task automatic t_idle_quiet();
        int seen = 0;
        for (int i = 0; i < 20; i++) begin
            if (busy || strobe != 0) seen++;
            @(negedge clk);
        end
        check(seen == 0, "R2", "no pass when unchanged", 32'(seen), 32'd0);
    endtask

    task automatic t_new_value(input logic [15:0] a, input logic [7:0] d);
        addr_in = a;
        data_in = d;
        @(negedge clk);
        check(busy == 1'b1, "R2", "busy one edge after change", 32'(busy), 32'd1);
        check_pass(a, d);
    endtask

    task automatic t_change_mid_pass();
        addr_in = 16'hA5C3;
        data_in = 8'h1E;
        @(negedge clk);
        fork
            check_pass(16'hA5C3, 8'h1E);
            begin
                repeat (8) @(negedge clk);
                addr_in = 16'h1111;
                repeat (10) @(negedge clk);
                addr_in = 16'h0F96;
                data_in = 8'h72;
            end
        join
        check(busy == 1'b0, "R6", "one idle cycle between passes", 32'(busy), 32'd0);
        @(negedge clk);
        check(busy == 1'b1, "R6", "follow-up pass started", 32'(busy), 32'd1);
        check_pass(16'h0F96, 8'h72);
    endtask

    task automatic t_revert();
        int seen = 0;
        addr_in = 16'h4D20;
        data_in = 8'h9B;
        @(negedge clk);
        fork
            check_pass(16'h4D20, 8'h9B);
            begin
                repeat (5) @(negedge clk);
                data_in = 8'h00;
                repeat (10) @(negedge clk);
                data_in = 8'h9B;
            end
        join
        for (int i = 0; i < 12; i++) begin
            if (busy) seen++;
            @(negedge clk);
        end
        check(seen == 0, "R7", "restored value starts nothing", 32'(seen), 32'd0);
    endtask

    task automatic t_blank();
        blank_req = 3'b101;
        @(negedge clk);
        check(blank == 3'b101, "R9", "blank follows request", 32'(blank), 32'h5);
        addr_in = 16'h7E01;
        @(negedge clk);
        fork
            check_pass(16'h7E01, 8'h9B);
            begin
                repeat (7) @(negedge clk);
                blank_req = 3'b010;
                @(negedge clk);
                check(blank == 3'b010, "R9", "blank during pass", 32'(blank), 32'h2);
                blank_req = 3'b000;
                @(negedge clk);
                check(blank == 3'b000, "R9", "blank cleared", 32'(blank), 32'h0);
            end
        join
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected below %0d", cycles, 20000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_idle_quiet();
        t_new_value(16'h1234, 8'h5A);
        t_new_value(16'hFEDC, 8'hBA);
        t_new_value(16'hFEDC, 8'h07);
        t_new_value(16'h3C80, 8'h07);
        t_change_mid_pass();
        t_revert();
        t_blank();
        t_idle_quiet();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule